// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block tracks the pending interrupt flag of each channel of a two-channel disk controller. Each flag is visible in two places: a legacy per-channel status byte and a shared mode byte. The shared mode byte also carries one block (mask) bit per channel. Whichever view software writes, the block copies the result into the other, so both views always agree. It drives one level-sensitive interrupt output. That output is high while any channel is pending and not blocked.

Software reaches the three bytes through a dword-addressed configuration write port with byte enables, and through a byte-wide combinational read port. Through the configuration port, the pending bits are write-1-to-clear and every other bit is read-only. A separate I/O window write path can change only the two block bits of the mode byte. Each channel's interrupt level input is edge-detected. A rising edge sets that channel's pending flag, a falling edge clears it, and a steady level leaves the flag alone, so software can clear a flag while the line is still high.

All state is registered and updates on the clock edge that samples the stimulus. The interrupt output is registered from the same next-state values, so it changes on that same edge.

Top module: `irq_mirror_top`

## Requirements
- R1: After a synchronous active-low reset, the bytes at byte offsets 0x50, 0x57 and 0x71 read 0x00 and `irq_out` is low.
- R2: Channel 0 pending is bit 2 of offset 0x50. Channel 1 pending is bit 4 of offset 0x57. In offset 0x71, bit 2 is channel 0 pending, bit 3 is channel 1 pending, bit 4 blocks channel 0 and bit 5 blocks channel 1. All other bits of these three bytes, and every other offset, read 0.
- R3: A configuration write clears each pending bit written as 1 in a selected byte. A pending bit written as 0 is kept. Block bits cannot be changed through the configuration port.
- R4: A configuration write whose enabled lanes include offset 0x50 or 0x57 copies both legacy pending bits into bits 2 and 3 of offset 0x71.
- R5: A configuration write whose enabled lanes include offset 0x71 copies bits 2 and 3 of 0x71 back into the legacy pending bits.
- R6: On a rising edge of `chan_irq_lvl[n]`, channel n becomes pending. On a falling edge, channel n stops pending. A steady level changes nothing. Both views are updated on the same clock edge.
- R7: `irq_out` is high exactly when (0x71 bit 2 and not bit 4) or (0x71 bit 3 and not bit 5).
- R8: An I/O window write (`io_wr_en`) loads bits 5:4 of `io_wr_data` into bits 5:4 of offset 0x71 and leaves the pending bits unchanged.
- R9: Configuration writes go byte by byte. `cfg_wr_addr` gives the dword, and `cfg_wr_be[k]` selects byte offset `cfg_wr_addr[7:2]*4+k` with data bits `8k+7:8k`. A byte with its enable low is left unchanged.
- R10: A rising edge of a channel input in the same cycle as a write-1-to-clear of that channel's pending bit leaves the bit set.
- R11: Every register and `irq_out` reflect a cycle's stimulus after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration dword byte address (bits 1:0 ignored) |
| cfg_wr_be | input | 4 | Byte lane enables |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_addr | input | 8 | Configuration read byte address |
| cfg_rd_data | output | 8 | Configuration read data (combinational) |
| chan_irq_lvl | input | 2 | Per-channel interrupt level inputs |
| io_wr_en | input | 1 | I/O window write strobe for the mode byte |
| io_wr_data | input | 8 | I/O window write data |
| irq_out | output | 1 | Level-sensitive interrupt output |

## Verification
The assertions check on every cycle that both legacy pending bits match the mode byte copy. They also check that the reserved bits stay zero, that `irq_out` matches the masked pending bits, that an edge on a channel input sets or clears its flag on the next edge, and that an I/O window write alone never moves a pending bit. Other behaviour shows only in the bench's scenarios:
- the write-1-to-clear semantics and the direction of each copy;
- byte enables that miss a register;
- a rise that coincides with a clear;
- software clearing a flag while the input is still high.

// File: rtl/irq_mirror_pkg.sv
// Package: offsets, bit positions and widths shared by the interrupt
// status mirror. Assumes byte-addressed configuration space, 8-bit bytes.
package irq_mirror_pkg;
    localparam int NUM_CH   = 2;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int LANES    = 4;
    localparam int DATA_W   = LANES * BYTE_W;

    localparam logic [ADDR_W-1:0] OFS_LEG0 = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_LEG1 = 8'h57;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h71;

    localparam int LEG0_PEND_BIT = 2;
    localparam int LEG1_PEND_BIT = 4;
    localparam int MODE_PEND_LSB = 2;
    localparam int MODE_BLK_LSB  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // Interrupt level from a mode byte: pending and not blocked, any channel.
    function automatic logic irq_level(input byte_t mode);
        logic lvl;
        lvl = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            lvl = lvl | (mode[MODE_PEND_LSB+c] & ~mode[MODE_BLK_LSB+c]);
        end
        return lvl;
    endfunction
endpackage

// File: rtl/cfg_lane_decode.sv
// Module: cfg_lane_decode
// Splits one dword configuration write into byte lanes and reports, per
// mirrored register, whether a lane hit it and which data byte landed
// there. Assumes at most one lane hits a given register per write.
module cfg_lane_decode
    import irq_mirror_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NL = LANES
) (
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NL-1:0]   wr_be,
    input  logic [NL*8-1:0] wr_data,
    output logic            hit_leg0,
    output logic            hit_leg1,
    output logic            hit_mode,
    output byte_t           dat_leg0,
    output byte_t           dat_leg1,
    output byte_t           dat_mode
);
    localparam int LSB_W = $clog2(NL);

    logic [NL-1:0] lane_leg0;
    logic [NL-1:0] lane_leg1;
    logic [NL-1:0] lane_mode;
    byte_t         lane_byte [NL];

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            logic [AW-1:0] lane_addr;
            // Byte address served by this lane.
            assign lane_addr    = {wr_addr[AW-1:LSB_W], LSB_W'(g)};
            assign lane_byte[g] = wr_data[g*8 +: 8];
            assign lane_leg0[g] = wr_en & wr_be[g] & (lane_addr == OFS_LEG0);
            assign lane_leg1[g] = wr_en & wr_be[g] & (lane_addr == OFS_LEG1);
            assign lane_mode[g] = wr_en & wr_be[g] & (lane_addr == OFS_MODE);
        end
    endgenerate

    assign hit_leg0 = |lane_leg0;
    assign hit_leg1 = |lane_leg1;
    assign hit_mode = |lane_mode;

    // Route the data byte of the hitting lane to each register.
    always_comb begin
        dat_leg0 = '0;
        dat_leg1 = '0;
        dat_mode = '0;
        for (int l = 0; l < NL; l++) begin
            if (lane_leg0[l]) dat_leg0 = dat_leg0 | lane_byte[l];
            if (lane_leg1[l]) dat_leg1 = dat_leg1 | lane_byte[l];
            if (lane_mode[l]) dat_mode = dat_mode | lane_byte[l];
        end
    end
endmodule

// File: rtl/chan_edge_detect.sv
// Module: chan_edge_detect
// Registers each channel's interrupt level and flags rising and falling
// edges. Assumes the levels are already synchronous to clk.
module chan_edge_detect #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lvl,
    output logic [NCH-1:0] rise,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] lvl_q;

    // Keep last cycle's levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/mirror_state.sv
// Module: mirror_state
// Holds the two legacy status bytes and the mode byte. Applies, in this
// order within one cycle: configuration write-1-to-clear with its
// directional copy, the I/O window block-bit load, then channel edges.
// Each step leaves both views in agreement. Exposes current and next
// mode bytes. Assumes one dword write per cycle.
module mirror_state
    import irq_mirror_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit_leg0,
    input  logic           hit_leg1,
    input  logic           hit_mode,
    input  byte_t          dat_leg0,
    input  byte_t          dat_leg1,
    input  byte_t          dat_mode,
    input  logic           io_wr_en,
    input  byte_t          io_wr_data,
    input  logic [NCH-1:0] rise,
    input  logic [NCH-1:0] fall,
    output byte_t          leg0_q,
    output byte_t          leg1_q,
    output byte_t          mode_q,
    output byte_t          mode_nx
);
    byte_t leg0_nx;
    byte_t leg1_nx;

    // Next-state sequencing of all sync events for this cycle.
    always_comb begin
        leg0_nx = leg0_q;
        leg1_nx = leg1_q;
        mode_nx = mode_q;
        if (hit_leg0) begin
            leg0_nx[LEG0_PEND_BIT] = leg0_nx[LEG0_PEND_BIT] & ~dat_leg0[LEG0_PEND_BIT];
            mode_nx[MODE_PEND_LSB]   = leg0_nx[LEG0_PEND_BIT];
            mode_nx[MODE_PEND_LSB+1] = leg1_nx[LEG1_PEND_BIT];
        end
        if (hit_leg1) begin
            leg1_nx[LEG1_PEND_BIT] = leg1_nx[LEG1_PEND_BIT] & ~dat_leg1[LEG1_PEND_BIT];
            mode_nx[MODE_PEND_LSB]   = leg0_nx[LEG0_PEND_BIT];
            mode_nx[MODE_PEND_LSB+1] = leg1_nx[LEG1_PEND_BIT];
        end
        if (hit_mode) begin
            for (int c = 0; c < NCH; c++) begin
                mode_nx[MODE_PEND_LSB+c] = mode_nx[MODE_PEND_LSB+c] & ~dat_mode[MODE_PEND_LSB+c];
            end
            leg0_nx[LEG0_PEND_BIT] = mode_nx[MODE_PEND_LSB];
            leg1_nx[LEG1_PEND_BIT] = mode_nx[MODE_PEND_LSB+1];
        end
        if (io_wr_en) begin
            mode_nx[MODE_BLK_LSB +: NCH] = io_wr_data[MODE_BLK_LSB +: NCH];
        end
        for (int c = 0; c < NCH; c++) begin
            if (rise[c])      mode_nx[MODE_PEND_LSB+c] = 1'b1;
            else if (fall[c]) mode_nx[MODE_PEND_LSB+c] = 1'b0;
        end
        leg0_nx[LEG0_PEND_BIT] = mode_nx[MODE_PEND_LSB];
        leg1_nx[LEG1_PEND_BIT] = mode_nx[MODE_PEND_LSB+1];
    end

    // Register the three bytes; reset clears pending and block bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg0_q <= '0;
            leg1_q <= '0;
            mode_q <= '0;
        end else begin
            leg0_q <= leg0_nx;
            leg1_q <= leg1_nx;
            mode_q <= mode_nx;
        end
    end

    AST_MIRROR_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        leg0_q[LEG0_PEND_BIT] == mode_q[MODE_PEND_LSB]);            // R4
    AST_MIRROR_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        leg1_q[LEG1_PEND_BIT] == mode_q[MODE_PEND_LSB+1]);          // R5
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((leg0_q & ~byte_t'(1 << LEG0_PEND_BIT)) == '0) &&
        ((leg1_q & ~byte_t'(1 << LEG1_PEND_BIT)) == '0) &&
        ((mode_q & 8'hC3) == '0));                                  // R2
    AST_RISE_SETS0: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> mode_q[MODE_PEND_LSB]);                         // R10
    AST_RISE_SETS1: assert property (@(posedge clk) disable iff (!rst_n)
        rise[1] |=> mode_q[MODE_PEND_LSB+1]);                       // R6
    AST_FALL_CLEARS0: assert property (@(posedge clk) disable iff (!rst_n)
        fall[0] |=> !mode_q[MODE_PEND_LSB]);                        // R6
    AST_IO_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && !hit_leg0 && !hit_leg1 && !hit_mode && rise == '0 && fall == '0)
        |=> $stable(mode_q[MODE_PEND_LSB +: NCH]));                 // R8
endmodule

// File: rtl/irq_drive.sv
// Module: irq_drive
// Registers the interrupt output from the next mode byte so it changes on
// the same edge as the registers. Assumes the mode layout in the package.
module irq_drive
    import irq_mirror_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t mode_nx,
    output logic  irq_out
);
    // Output flop of the combined interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= irq_level(mode_nx);
    end
endmodule

// File: rtl/irq_mirror_top.sv
// Module: irq_mirror_top
// Dual-channel interrupt status mirror: configuration write/read port,
// I/O window block-bit write, two channel level inputs, one interrupt.
// Assumes all inputs synchronous to clk.
module irq_mirror_top
    import irq_mirror_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [LANES-1:0]  cfg_wr_be,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic [BYTE_W-1:0] cfg_rd_data,
    input  logic [NUM_CH-1:0] chan_irq_lvl,
    input  logic              io_wr_en,
    input  logic [BYTE_W-1:0] io_wr_data,
    output logic              irq_out
);
    logic              hit_leg0, hit_leg1, hit_mode;
    byte_t             dat_leg0, dat_leg1, dat_mode;
    logic [NUM_CH-1:0] rise, fall;
    byte_t             leg0_q, leg1_q, mode_q, mode_nx;

    cfg_lane_decode #(.AW(ADDR_W), .NL(LANES)) u_dec (
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_be(cfg_wr_be),
        .wr_data(cfg_wr_data), .hit_leg0(hit_leg0), .hit_leg1(hit_leg1),
        .hit_mode(hit_mode), .dat_leg0(dat_leg0), .dat_leg1(dat_leg1),
        .dat_mode(dat_mode)
    );

    chan_edge_detect #(.NCH(NUM_CH)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(chan_irq_lvl), .rise(rise), .fall(fall)
    );

    mirror_state #(.NCH(NUM_CH)) u_state (
        .clk(clk), .rst_n(rst_n), .hit_leg0(hit_leg0), .hit_leg1(hit_leg1),
        .hit_mode(hit_mode), .dat_leg0(dat_leg0), .dat_leg1(dat_leg1),
        .dat_mode(dat_mode), .io_wr_en(io_wr_en), .io_wr_data(io_wr_data),
        .rise(rise), .fall(fall), .leg0_q(leg0_q), .leg1_q(leg1_q),
        .mode_q(mode_q), .mode_nx(mode_nx)
    );

    irq_drive u_irq (
        .clk(clk), .rst_n(rst_n), .mode_nx(mode_nx), .irq_out(irq_out)
    );

    // Byte read mux over the three mirrored offsets; others read zero.
    always_comb begin
        unique case (cfg_rd_addr)
            OFS_LEG0: cfg_rd_data = leg0_q;
            OFS_LEG1: cfg_rd_data = leg1_q;
            OFS_MODE: cfg_rd_data = mode_q;
            default:  cfg_rd_data = '0;
        endcase
    end

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ((mode_q[2] & ~mode_q[4]) | (mode_q[3] & ~mode_q[5]))); // R7
endmodule

// File: tb/sim_irq_mirror_top.sv
`timescale 1ns/100ps
module sim_irq_mirror_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [7:0]  cfg_rd_data;
    logic [1:0]  chan_irq_lvl = '0;
    logic        io_wr_en = 1'b0;
    logic [7:0]  io_wr_data = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Reference state built from the requirements.
    logic [1:0] m_pend = '0;
    logic [1:0] m_blk  = '0;
    logic [1:0] m_prev = '0;

    always #2 clk = ~clk;

    irq_mirror_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_data(cfg_rd_data), .chan_irq_lvl(chan_irq_lvl), .io_wr_en(io_wr_en),
        .io_wr_data(io_wr_data), .irq_out(irq_out)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        case (a)
            8'h50:   return {5'b0, m_pend[0], 2'b0};
            8'h57:   return {3'b0, m_pend[1], 4'b0};
            8'h71:   return {2'b0, m_blk, m_pend, 2'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_pend[0] & ~m_blk[0]) | (m_pend[1] & ~m_blk[1]);
    endfunction

    // Reference update for one cycle of the currently driven inputs.
    task automatic model_step();
        logic [1:0] clr;
        clr = '0;
        if (cfg_wr_en) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ba;
                logic [7:0] bd;
                ba = {cfg_wr_addr[7:2], 2'(k)};
                bd = cfg_wr_data[8*k +: 8];
                if (cfg_wr_be[k]) begin
                    if (ba == 8'h50) clr[0] = clr[0] | bd[2];
                    if (ba == 8'h57) clr[1] = clr[1] | bd[4];
                    if (ba == 8'h71) clr = clr | bd[3:2];
                end
            end
        end
        m_pend = m_pend & ~clr;
        if (io_wr_en) m_blk = io_wr_data[5:4];
        for (int c = 0; c < 2; c++) begin
            if (chan_irq_lvl[c] && !m_prev[c]) m_pend[c] = 1'b1;
            else if (!chan_irq_lvl[c] && m_prev[c]) m_pend[c] = 1'b0;
        end
        m_prev = chan_irq_lvl;
    endtask

    task automatic check_all(input string req);
        logic [7:0] addrs [4] = '{8'h50, 8'h57, 8'h71, 8'h6C};
        for (int i = 0; i < 4; i++) begin
            cfg_rd_addr = addrs[i];
            #0.3;
            n_chk++;
            if (cfg_rd_data !== exp_byte(addrs[i])) begin
                n_bad++;
                $display("FAIL %s off=%h actual=%h expected=%h", req, addrs[i], cfg_rd_data, exp_byte(addrs[i]));
            end
        end
        n_chk++;
        if (irq_out !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s R7 irq actual=%b expected=%b", req, irq_out, exp_irq());
        end
    endtask

    // Apply the driven inputs for one edge, then check at the negedge.
    task automatic step(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0; io_wr_en = 1'b0; cfg_wr_be = '0;
        check_all(req);
    endtask

    task automatic cfgw(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_be = be; cfg_wr_data = d;
    endtask

    task automatic iow(input logic [7:0] d);
        io_wr_en = 1'b1; io_wr_data = d;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        chan_irq_lvl = 2'b01; step("R6 rise ch0 sets both views");
        iow(8'hFF);           step("R8 io write only block bits");
        cfgw(8'h70, 4'b0010, 32'h0000_FF00); step("R3 R5 W1C on mode, block kept");
        chan_irq_lvl = 2'b11; step("R6 rise ch1");
        iow(8'h00);           step("R8 unblock");
        cfgw(8'h54, 4'b1000, 32'h1000_0000); step("R4 clear legacy ch1 copies to mode");
        chan_irq_lvl = 2'b01; step("R6 fall ch1");
        chan_irq_lvl = 2'b11; step("R6 rise ch1 again");
        cfgw(8'h54, 4'b0111, 32'hFFFF_FFFF); step("R9 disabled lane ignored");
        cfgw(8'h50, 4'b0001, 32'h0000_00FB); step("R3 zero in pending bit keeps it");
        cfgw(8'h54, 4'b1111, 32'hFFFF_FFFF); step("R9 enabled lane clears");
        chan_irq_lvl = 2'b10; step("R6 fall ch0");
        chan_irq_lvl = 2'b11;
        cfgw(8'h50, 4'b0001, 32'h0000_0004); step("R10 rise with clear keeps set");
        cfgw(8'h50, 4'b0001, 32'h0000_0004); step("R3 clear while level high");
        iow(8'h10); chan_irq_lvl = 2'b10; step("R11 R7 simultaneous io and fall");

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] sel;
            if ($urandom_range(0, 1) == 1) begin
                sel = 2'($urandom_range(0, 3));
                cfgw(sel == 0 ? 8'h50 : sel == 1 ? 8'h54 : sel == 2 ? 8'h70 : 8'h40,
                     4'($urandom), $urandom);
            end
            if ($urandom_range(0, 3) == 0) iow(8'($urandom));
            if ($urandom_range(0, 2) == 0) chan_irq_lvl = 2'($urandom);
            step("R11 random");
        end
        finish_run();
    end
endmodule